// File: doc/BRIEF.md
# Sized-Access Vector Register File

This block holds the floating-point and vector operand state of a processor core: thirty-two entries of 128 bits, kept apart from the integer register storage. Every port names an entry index and an access size. A scalar access covers the low 8, 16, 32, 64 or 128 bits of an entry. A vector access covers all 128 bits as one unit.

Two combinational read ports and one write port are provided, and every data bus is 128 bits wide. A scalar write clears every bit of the entry above the written width, so a narrow result never leaves stale upper lanes behind. A vector write, or a quad write, replaces the whole entry. A scalar read returns the selected low bits zero-extended to the full bus width. Entry 31 behaves like every other entry.

Top module: `simd_regfile`

## Requirements
- R1: There are 32 independent 128-bit entries, indexed 0 to 31, and entry 31 is an ordinary entry. Reset clears every entry to zero.
- R2: The size code is 3 bits wide: 0 is byte (8 bits), 1 is half (16), 2 is single (32), 3 is double (64), 4 is quad (128) and 5 is vector (128). A scalar write with code 0 to 3 stores the low 8, 16, 32 or 64 bits of `wr_data` into the low bits of the entry.
- R3: A scalar write with size code 0 to 3 sets every entry bit at or above the written width to zero.
- R4: A write with code 4 (quad) or code 5 (vector) replaces all 128 bits of the entry with `wr_data`. The two codes store identical results.
- R5: A write with size code 6 or 7 changes no entry.
- R6: A read with code 0 to 3 returns the entry's low 8, 16, 32 or 64 bits, zero-extended to 128 bits. A read with code 4 or 5 returns all 128 bits. A read with code 6 or 7 returns zero.
- R7: A write takes effect at the rising clock edge. A read of the entry being written in the same cycle returns the entry's old contents.
- R8: The two read ports work independently and may select different entries and sizes in the same cycle.
- R9: While `wr_en` is low, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all entries |
| rd0_idx | input | 5 | Entry index for read port 0 |
| rd0_size | input | 3 | Access size code for read port 0 |
| rd0_data | output | 128 | Read port 0 data, zero-extended for scalar sizes |
| rd1_idx | input | 5 | Entry index for read port 1 |
| rd1_size | input | 3 | Access size code for read port 1 |
| rd1_data | output | 128 | Read port 1 data, zero-extended for scalar sizes |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Entry index for the write |
| wr_size | input | 3 | Access size code for the write |
| wr_data | input | 128 | Write data; only the sized low part is used |

## Verification
The assertions check four things on every cycle: after any scalar write the upper bits of the entry are zero, the sized low part holds the written data, quad and vector writes hold the full word, and codes 6 and 7 leave the entry unchanged. Other behaviours can only be shown by the bench's scenarios. These are the reset contents of all 32 entries, zero extension and the null result on the read buses, the old-value result when a read and a write hit the same entry in one cycle, the two read ports working independently, and a disabled write leaving all state untouched. The bench also shows that entry 31 is not special.

// File: rtl/simd_regfile.sv
module simd_regfile #(
  parameter int NREGS = 32,
  parameter int DW    = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NREGS)-1:0] rd0_idx,
  input  logic [2:0]               rd0_size,
  output logic [DW-1:0]            rd0_data,
  input  logic [$clog2(NREGS)-1:0] rd1_idx,
  input  logic [2:0]               rd1_size,
  output logic [DW-1:0]            rd1_data,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_idx,
  input  logic [2:0]               wr_size,
  input  logic [DW-1:0]            wr_data
);
  localparam logic [2:0] SZ_DBL = 3'd3;
  localparam logic [2:0] SZ_VEC = 3'd5;

  function automatic logic [DW-1:0] size_mask(input logic [2:0] sz);
    case (sz)
      3'd0:    return {DW{1'b1}} >> (DW - 8);
      3'd1:    return {DW{1'b1}} >> (DW - 16);
      3'd2:    return {DW{1'b1}} >> (DW - 32);
      3'd3:    return {DW{1'b1}} >> (DW - 64);
      3'd4,
      3'd5:    return {DW{1'b1}};
      default: return '0;
    endcase
  endfunction

  logic [DW-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en && wr_size <= SZ_VEC) begin
      regs[wr_idx] <= wr_data & size_mask(wr_size);
    end
  end

  assign rd0_data = regs[rd0_idx] & size_mask(rd0_size);
  assign rd1_data = regs[rd1_idx] & size_mask(rd1_size);

  assert_scalar_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size <= SZ_DBL) |=>
      ((regs[$past(wr_idx)] & ~size_mask($past(wr_size))) == '0));

  assert_scalar_low_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size <= SZ_DBL) |=>
      ((regs[$past(wr_idx)] & size_mask($past(wr_size))) ==
       ($past(wr_data) & size_mask($past(wr_size)))));

  assert_full_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_size == 3'd4 || wr_size == SZ_VEC)) |=>
      (regs[$past(wr_idx)] == $past(wr_data)));

  assert_null_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size > SZ_VEC) |=>
      (regs[$past(wr_idx)] == $past(regs[wr_idx])));
endmodule

// File: tb/simd_regfile_bench.sv
module simd_regfile_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [2:0]   rd0_size = '0, rd1_size = '0, wr_size = '0;
  logic         wr_en = 1'b0;
  logic [127:0] wr_data = '0;
  logic [127:0] rd0_data, rd1_data;

  int checks = 0;
  int errors = 0;
  logic [127:0] model [32];
  logic [127:0] exp0_q[$];
  logic [127:0] exp1_q[$];
  string        tag_q[$];
  event         item_ready;

  always #2.5 clk = ~clk;

  simd_regfile u_simd_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data)
  );

  function automatic logic [127:0] msk(input logic [2:0] sz);
    case (sz)
      3'd0: return 128'hFF;
      3'd1: return 128'hFFFF;
      3'd2: return 128'hFFFF_FFFF;
      3'd3: return 128'hFFFF_FFFF_FFFF_FFFF;
      3'd4, 3'd5: return {128{1'b1}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [127:0] pat(input int i, input int k);
    logic [31:0] b;
    b = 32'h9E37_79B9 * (i + 1) + 32'(k) * 32'h0101_0101;
    return {b ^ 32'hA5A5_0F0F, ~b, b + 32'h1357_9BDF, b};
  endfunction

  task automatic step(input int r0, input logic [2:0] s0, input int r1, input logic [2:0] s1,
                      input logic we, input int wi, input logic [2:0] ws,
                      input logic [127:0] wd, input string tag);
    @(negedge clk);
    rd0_idx = 5'(r0); rd0_size = s0; rd1_idx = 5'(r1); rd1_size = s1;
    wr_en = we; wr_idx = 5'(wi); wr_size = ws; wr_data = wd;
    exp0_q.push_back(model[r0] & msk(s0));
    exp1_q.push_back(model[r1] & msk(s1));
    tag_q.push_back(tag);
    if (we && ws <= 3'd5) model[wi] = wd & msk(ws);
    #1 -> item_ready;
  endtask

  initial begin : monitor
    forever begin
      @(item_ready);
      while (exp0_q.size() > 0) begin
        logic [127:0] e0, e1;
        string t;
        e0 = exp0_q.pop_front(); e1 = exp1_q.pop_front(); t = tag_q.pop_front();
        checks += 2;
        if (rd0_data !== e0) begin
          errors++;
          $display("FAIL %s port0 actual %h expected %h", t, rd0_data, e0);
        end
        if (rd1_data !== e1) begin
          errors++;
          $display("FAIL %s port1 actual %h expected %h", t, rd1_data, e1);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: every entry reads zero after reset
    for (int i = 0; i < 32; i++) step(i, 3'd5, 31 - i, 3'd4, 1'b0, 0, 3'd0, '0, "R1 reset");
    // R4 / R1: vector write of every entry, then read it back on both ports
    for (int i = 0; i < 32; i++) step(0, 3'd5, 0, 3'd5, 1'b1, i, 3'd5, pat(i, 1), "R4 vector fill");
    for (int i = 0; i < 32; i++) step(i, 3'd5, (i + 7) % 32, 3'd4, 1'b0, 0, 3'd0, '0, "R1 R8 readback");
    // R6: all read sizes from a full entry
    for (int s = 0; s < 8; s++) step(9, 3'(s), 31, 3'(7 - s), 1'b0, 0, 3'd0, '0, "R6 read sizes");
    // R2 R3: scalar writes of each size over full entries
    for (int s = 0; s < 4; s++) begin
      step(0, 3'd5, 0, 3'd5, 1'b1, 10 + s, 3'(s), pat(40 + s, 3), "R2 R3 scalar write");
      step(10 + s, 3'd5, 10 + s, 3'(s), 1'b0, 0, 3'd0, '0, "R3 upper cleared");
    end
    // R4: quad write matches vector write
    step(0, 3'd5, 0, 3'd5, 1'b1, 20, 3'd4, pat(77, 2), "R4 quad write");
    step(0, 3'd5, 0, 3'd5, 1'b1, 21, 3'd5, pat(77, 2), "R4 vector write");
    step(20, 3'd5, 21, 3'd4, 1'b0, 0, 3'd0, '0, "R4 quad equals vector");
    // R5: null write codes leave the entry intact
    step(0, 3'd5, 0, 3'd5, 1'b1, 5, 3'd6, pat(90, 0), "R5 code 6");
    step(0, 3'd5, 0, 3'd5, 1'b1, 5, 3'd7, pat(91, 0), "R5 code 7");
    step(5, 3'd5, 5, 3'd3, 1'b0, 0, 3'd0, '0, "R5 entry unchanged");
    // R9: disabled write
    step(0, 3'd5, 0, 3'd5, 1'b0, 6, 3'd5, pat(92, 0), "R9 write disabled");
    step(6, 3'd5, 6, 3'd0, 1'b0, 0, 3'd0, '0, "R9 entry unchanged");
    // R7: same-cycle read of the written entry returns old data
    step(31, 3'd5, 31, 3'd0, 1'b1, 31, 3'd5, pat(93, 5), "R7 old value");
    step(31, 3'd5, 31, 3'd1, 1'b1, 31, 3'd1, pat(94, 5), "R7 old value");
    step(31, 3'd5, 31, 3'd1, 1'b0, 0, 3'd0, '0, "R7 R3 new value");
    // R8: both ports on different entries and sizes across the file
    for (int i = 0; i < 32; i++) step(i, 3'(i % 6), 31 - i, 3'((i + 3) % 8), 1'b0, 0, 3'd0, '0, "R8 dual read");
    @(negedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule